// File: doc/BRIEF.md
# High-Speed Burst Lane Sequencer

This block sequences one transmit lane of a differential serial link. The lane rests in a low-power state. When a burst is requested it runs a fixed single-ended handshake on the two low-power line levels. It then switches the high-speed driver on and sends a run of zero bits followed by a fixed sync byte. Next it serializes the payload bytes, two bits per clock, one on each edge. It closes the burst with a trailer and returns to rest. Analog drivers, termination, packet framing and the reverse direction are handled elsewhere.

Payload enters over a valid/ready byte stream. The block applies back-pressure by keeping `s_ready` low on every cycle except the last clock of each byte slot, which is the only cycle where a new byte can be taken. A source that holds `s_valid` low on such a cycle ends the burst. `tx_req` is a plain level that is sampled only while the lane is at rest. The two bits of each clock appear in parallel on `hs_pair` and are also merged onto a double-data-rate line `hs_ser`.

Top module: `hs_lane_tx`

## Requirements
- R1: At rest and after reset the lane drives lp_p=1 and lp_n=1, with hs_en=0 and s_ready=0.
- R2: When tx_req is high at rest, the next cycles drive lp_p=0 and lp_n=1 for LP01_CYC clocks, then lp_p=0 and lp_n=0 for LP00_CYC clocks, with hs_en=0 throughout.
- R3: Straight after that, hs_en goes high and hs_pair=2'b00 for ZERO_CYC clocks. While hs_en is high, lp_p and lp_n are both 0.
- R4: The sync byte 8'h1D (binary 00011101) follows the zero run over four clocks, least significant bit first.
- R5: Each clock carries two bits: hs_pair[0] is the earlier bit and hs_pair[1] the later one. hs_ser shows hs_pair[0] while clk is high and hs_pair[1] while clk is low. Every byte is sent LSB first.
- R6: s_ready is high only on the last of the four clocks of the sync byte and of each payload byte. A byte taken with s_valid and s_ready both high is sent over the next four clocks with no gap. s_valid and s_data are ignored while s_ready is low.
- R7: s_valid low on a cycle where s_ready is high ends the burst. For TRAIL_CYC clocks both bits of hs_pair carry the inverse of the last bit sent (the sync byte's bit 7 if no payload was taken). The lane then returns to the R1 state.
- R8: tx_req has no effect while a burst is in progress.
- R9: An active-low asynchronous reset returns the lane to the R1 state at once, even in mid-burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte-slot clock; bits move on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Burst request, sampled at rest |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | 8 | Payload byte |
| s_ready | output | 1 | Byte slot open |
| lp_p | output | 1 | Positive low-power line level |
| lp_n | output | 1 | Negative low-power line level |
| hs_en | output | 1 | High-speed driver enable |
| hs_pair | output | 2 | Bits for this clock, [0] first |
| hs_ser | output | 1 | Double-data-rate serial bit |

## Verification
Two functions can fall in the same cycle: taking the next byte and deciding whether the burst ends. Both are settled on the ready cycle, where the last two bits of the current byte are also being driven. The bench provokes this by keeping s_valid high with junk data on closed slots. On each ready cycle it either offers the next byte or drops valid. An empty burst moves the same decision onto the sync byte. The bench then checks that every byte follows the previous one with no gap, that junk never reaches the line, and that the trailer level is the inverse of the final bit sent.

// File: rtl/hs_lane_pkg.sv
package hs_lane_pkg;
  typedef enum logic [2:0] {
    ST_REST, ST_LP01, ST_LP00, ST_ZERO, ST_SYNC, ST_DATA, ST_TRAIL
  } lane_st_e;

  localparam int BYTE_W        = 8;
  localparam int BITS_PER_CLK  = 2;
  localparam int SLOT_CLKS     = BYTE_W / BITS_PER_CLK;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'b00011101;
endpackage

// File: rtl/lane_seq_fsm.sv
module lane_seq_fsm
  import hs_lane_pkg::*;
#(
  parameter int LP01_CYC  = 2,
  parameter int LP00_CYC  = 3,
  parameter int ZERO_CYC  = 4,
  parameter int TRAIL_CYC = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tx_req,
  input  logic     s_valid,
  output lane_st_e st,
  output logic     slot_end,
  output logic     sync_start,
  output logic     load,
  output logic     burst_end
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXC = imax(imax(imax(LP01_CYC, LP00_CYC), imax(ZERO_CYC, TRAIL_CYC)), SLOT_CLKS);
  localparam int CW   = $clog2(MAXC) + 1;

  lane_st_e      st_nx;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          ph_end;

  always_comb begin
    case (st)
      ST_LP01:          lim = CW'(LP01_CYC - 1);
      ST_LP00:          lim = CW'(LP00_CYC - 1);
      ST_ZERO:          lim = CW'(ZERO_CYC - 1);
      ST_SYNC, ST_DATA: lim = CW'(SLOT_CLKS - 1);
      ST_TRAIL:         lim = CW'(TRAIL_CYC - 1);
      default:          lim = '0;
    endcase
  end

  assign ph_end     = (cnt == lim);
  assign slot_end   = ((st == ST_SYNC) || (st == ST_DATA)) && ph_end;
  assign load       = slot_end && s_valid;
  assign burst_end  = slot_end && !s_valid;
  assign sync_start = (st == ST_ZERO) && ph_end;

  always_comb begin
    st_nx = st;
    case (st)
      ST_REST:  if (tx_req) st_nx = ST_LP01;
      ST_LP01:  if (ph_end) st_nx = ST_LP00;
      ST_LP00:  if (ph_end) st_nx = ST_ZERO;
      ST_ZERO:  if (ph_end) st_nx = ST_SYNC;
      ST_SYNC, ST_DATA: begin
        if (load)           st_nx = ST_DATA;
        else if (burst_end) st_nx = ST_TRAIL;
      end
      ST_TRAIL: if (ph_end) st_nx = ST_REST;
      default:  st_nx = ST_REST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_REST;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= ph_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import hs_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lane_st_e          st,
  input  logic              sync_start,
  input  logic              load,
  input  logic              burst_end,
  input  logic [BYTE_W-1:0] s_data,
  output logic [1:0]        hs_pair
);
  logic [BYTE_W-1:0] sreg;
  logic              trl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      trl_lvl <= 1'b0;
    end else begin
      if (sync_start)
        sreg <= SYNC_BYTE;
      else if (load)
        sreg <= s_data;
      else if ((st == ST_SYNC) || (st == ST_DATA))
        sreg <= {{BITS_PER_CLK{1'b0}}, sreg[BYTE_W-1:BITS_PER_CLK]};
      if (burst_end)
        trl_lvl <= ~sreg[BITS_PER_CLK-1];
    end
  end

  always_comb begin
    case (st)
      ST_SYNC, ST_DATA: hs_pair = sreg[1:0];
      ST_TRAIL:         hs_pair = {2{trl_lvl}};
      default:          hs_pair = 2'b00;
    endcase
  end
endmodule

// File: rtl/lane_ddr_out.sv
module lane_ddr_out (
  input  logic       clk,
  input  logic [1:0] pair,
  output logic       ser
);
  assign ser = clk ? pair[0] : pair[1];
endmodule

// File: rtl/hs_lane_tx.sv
module hs_lane_tx
  import hs_lane_pkg::*;
#(
  parameter int LP01_CYC  = 2,
  parameter int LP00_CYC  = 3,
  parameter int ZERO_CYC  = 4,
  parameter int TRAIL_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  output logic       s_ready,
  output logic       lp_p,
  output logic       lp_n,
  output logic       hs_en,
  output logic [1:0] hs_pair,
  output logic       hs_ser
);
  lane_st_e st;
  logic     slot_end, sync_start, load, burst_end;

  lane_seq_fsm #(
    .LP01_CYC (LP01_CYC),
    .LP00_CYC (LP00_CYC),
    .ZERO_CYC (ZERO_CYC),
    .TRAIL_CYC(TRAIL_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .s_valid   (s_valid),
    .st        (st),
    .slot_end  (slot_end),
    .sync_start(sync_start),
    .load      (load),
    .burst_end (burst_end)
  );

  lane_shifter u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .sync_start(sync_start),
    .load      (load),
    .burst_end (burst_end),
    .s_data    (s_data),
    .hs_pair   (hs_pair)
  );

  lane_ddr_out u_ddr (
    .clk (clk),
    .pair(hs_pair),
    .ser (hs_ser)
  );

  assign s_ready = slot_end;

  always_comb begin
    case (st)
      ST_REST: begin lp_p = 1'b1; lp_n = 1'b1; hs_en = 1'b0; end
      ST_LP01: begin lp_p = 1'b0; lp_n = 1'b1; hs_en = 1'b0; end
      ST_LP00: begin lp_p = 1'b0; lp_n = 1'b0; hs_en = 1'b0; end
      default: begin lp_p = 1'b0; lp_n = 1'b0; hs_en = 1'b1; end
    endcase
  end
endmodule

// File: rtl/hs_lane_tx_chk.sv
module hs_lane_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_p,
  input logic       lp_n,
  input logic       hs_en,
  input logic       s_ready,
  input logic [1:0] hs_pair
);
  a_r3_lp_low_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (!lp_p && !lp_n));

  a_r2_lp01_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_en && $past(lp_p && lp_n) && !(lp_p && lp_n)) |-> (!lp_p && lp_n));

  a_r3_zero_run_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> (hs_pair == 2'b00));

  a_r6_ready_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> hs_en);

  a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> (!s_ready && hs_en));

  a_r7_rest_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> (lp_p && lp_n));
endmodule

bind hs_lane_tx hs_lane_tx_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .lp_p   (lp_p),
  .lp_n   (lp_n),
  .hs_en  (hs_en),
  .s_ready(s_ready),
  .hs_pair(hs_pair)
);

// File: tb/hs_lane_tx_tb.sv
module hs_lane_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_LP01  = 2;
  localparam int P_LP00  = 3;
  localparam int P_ZERO  = 4;
  localparam int P_TRAIL = 3;
  localparam logic [7:0] SYNC_B = 8'h1D;
  localparam int NVEC = 5;
  // {byte count, first byte, expected trailer level}; bytes are first+i
  localparam logic [16:0] VEC [NVEC] = '{
    {8'd1, 8'hA5, 1'b0},
    {8'd3, 8'h3C, 1'b1},
    {8'd0, 8'h00, 1'b1},
    {8'd2, 8'h7F, 1'b0},
    {8'd4, 8'hF0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_req = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_ready, lp_p, lp_n, hs_en, hs_ser;
  logic [1:0] hs_pair;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_lane_tx #(
    .LP01_CYC(P_LP01), .LP00_CYC(P_LP00), .ZERO_CYC(P_ZERO), .TRAIL_CYC(P_TRAIL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en),
    .hs_pair(hs_pair), .hs_ser(hs_ser)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_line(input string req, input logic [1:0] lp, input logic hs, input logic rdy);
    logic [3:0] act, exp;
    act = {lp_p, lp_n, hs_en, s_ready};
    exp = {lp, hs, rdy};
    chk(act == exp, req, int'(act), int'(exp));
  endtask

  task automatic run_burst(input int nb, input logic [7:0] base, input logic exp_t, input bit poke);
    logic [7:0] b;
    @(negedge clk);
    chk_line("R1 rest", 2'b11, 1'b0, 1'b0);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    for (int i = 0; i < P_LP01; i++) begin
      chk_line("R2 lp01", 2'b01, 1'b0, 1'b0);
      @(negedge clk);
    end
    for (int i = 0; i < P_LP00; i++) begin
      chk_line("R2 lp00", 2'b00, 1'b0, 1'b0);
      @(negedge clk);
    end
    for (int i = 0; i < P_ZERO; i++) begin
      chk_line("R3 zero", 2'b00, 1'b1, 1'b0);
      chk(hs_pair == 2'b00, "R3 zero bits", int'(hs_pair), 0);
      if (poke) tx_req = 1'b1;  // R8: request while busy
      @(negedge clk);
    end
    tx_req = 1'b0;
    for (int j = 0; j < 4; j++) begin
      chk_line("R6 sync ready", 2'b00, 1'b1, j == 3);
      chk(hs_pair == {SYNC_B[2*j+1], SYNC_B[2*j]}, "R4 sync", int'(hs_pair),
          int'({SYNC_B[2*j+1], SYNC_B[2*j]}));
      chk(hs_ser == hs_pair[1], "R5 ddr low half", int'(hs_ser), int'(hs_pair[1]));
      if (j == 3) begin
        s_valid = (nb > 0);
        s_data  = base;
      end else begin
        s_valid = 1'b1;   // R6: ignored while ready is low
        s_data  = 8'hFF;
      end
      if (j == 0) begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(hs_ser == SYNC_B[2], "R5 ddr high half", int'(hs_ser), int'(SYNC_B[2]));
      end
      @(negedge clk);
    end
    for (int k = 0; k < nb; k++) begin
      b = base + 8'(k);
      for (int j = 0; j < 4; j++) begin
        chk_line("R6 data ready", 2'b00, 1'b1, j == 3);
        chk(hs_pair == {b[2*j+1], b[2*j]}, "R5 payload lsb first", int'(hs_pair),
            int'({b[2*j+1], b[2*j]}));
        if (j == 3) begin
          s_valid = (k + 1 < nb);  // R7: drop ends the burst
          s_data  = base + 8'(k + 1);
        end else begin
          s_valid = 1'b1;
          s_data  = ~b;
        end
        @(negedge clk);
      end
    end
    s_valid = 1'b0;
    for (int t = 0; t < P_TRAIL; t++) begin
      chk_line("R7 trailer", 2'b00, 1'b1, 1'b0);
      chk(hs_pair == {exp_t, exp_t}, "R7 trailer level", int'(hs_pair), int'({exp_t, exp_t}));
      @(negedge clk);
    end
    chk_line("R7 back to rest", 2'b11, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    chk(P_LP01 >= 1 && P_LP00 >= 1 && P_ZERO >= 1 && P_TRAIL >= 1, "R2 minimum phase lengths",
        P_LP01, 1);
    #(CLK_PERIOD/4);
    chk_line("R1 in reset", 2'b11, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_line("R1 after reset", 2'b11, 1'b0, 1'b0);

    for (int v = 0; v < NVEC; v++)
      run_burst(int'(VEC[v][16:9]), VEC[v][8:1], VEC[v][0], v == 2);

    // R8: rest holds with no request
    repeat (3) begin
      @(negedge clk);
      chk_line("R8 rest without request", 2'b11, 1'b0, 1'b0);
    end

    // R9: reset in mid-payload
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    s_valid = 1'b1;
    s_data  = 8'h55;
    repeat (P_LP01 + P_LP00 + P_ZERO + 6) @(negedge clk);
    chk(hs_en == 1'b1, "R9 burst running", int'(hs_en), 1);
    rst_n = 1'b0;
    #1;
    chk_line("R9 async reset", 2'b11, 1'b0, 1'b0);
    s_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_line("R9 rest after reset", 2'b11, 1'b0, 1'b0);
    run_burst(2, 8'h81, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule